// File: doc/BRIEF.md
# Interrupt Entry and Return Stack Sequencer

This block carries out the processor-side memory traffic for going into an interrupt handler and coming back out of it. An entry request names an 8-bit interrupt type. The sequencer saves the current flags, code segment and instruction pointer on a word-wide stack that grows downward. It removes the interrupt-enable and single-step permissions from the flags it hands back. It then reads the handler's instruction pointer and code segment from a four-byte-per-entry vector table that starts at physical address zero. A return request reverses this. It reads the instruction pointer, the code segment and the flags back off the stack and moves the stack pointer up past them.

The caller presents the architectural values (flags, CS, IP, SS, SP) on the `cur_*` inputs together with a one-cycle start pulse. It then waits for `done`. In the cycle `done` is high, the `nxt_*` outputs carry the updated values. Every memory access uses one 16-bit word, a 20-bit physical address and a `mem_ready` handshake.

States:
- `S_IDLE`
- entry path: `S_PUSH_FL` → `S_PUSH_CS` → `S_PUSH_IP` → `S_RD_IP` → `S_RD_CS` → `S_FIN`
- return path: `S_POP_IP` → `S_POP_CS` → `S_POP_FL` → `S_FIN`
- `S_FIN` → `S_IDLE`

Transitions:
- `S_IDLE` leaves on an accepted start.
- Every memory state advances only on `mem_ready`.
- `S_FIN` always returns to `S_IDLE`.

Top module: `irq_frame_seq`

## Requirements
- R1: During and after reset, `busy`, `done`, `mem_req` and `mem_we` are 0.
- R2: Entry writes three words, in this order: the flags exactly as sampled at SS:SP-2, then CS at SS:SP-4, then IP at SS:SP-6. The physical address is SS*16+SP.
- R3: After entry, `nxt_flags` equals the sampled flags with bit 9 (interrupt enable) and bit 8 (single step) cleared. All other bits are unchanged.
- R4: After entry, `nxt_ip` is the word read at type*4, `nxt_cs` is the word read at type*4+2, and `nxt_sp` is SP-6.
- R5: Return reads IP at SS:SP, CS at SS:SP+2 and flags at SS:SP+4. The results appear on `nxt_ip`, `nxt_cs` and `nxt_flags` unmodified, with `nxt_sp` = SP+6.
- R6: The stack pointer wraps modulo 2^16 and the physical address wraps modulo 2^20.
- R7: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values. The sequence advances only on `mem_ready`.
- R8: `done` is a single-cycle pulse, once per accepted request. `busy` is high from the cycle after the start until `done`.
- R9: If `entry_go` and `ret_go` are both high in an idle cycle, entry is performed. Start pulses arriving while busy are ignored.
- R10: `mem_we` is high only in the three entry push accesses. A return issues no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_go | input | 1 | Start interrupt entry |
| ret_go | input | 1 | Start interrupt return |
| irq_type | input | 8 | Interrupt type for entry |
| cur_flags | input | 16 | Flags to save |
| cur_cs | input | 16 | Code segment to save |
| cur_ip | input | 16 | Instruction pointer to save |
| cur_ss | input | 16 | Stack segment |
| cur_sp | input | 16 | Stack pointer at start |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | 20 | Physical word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with ready |
| mem_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| nxt_flags | output | 16 | Resulting flags |
| nxt_cs | output | 16 | Resulting code segment |
| nxt_ip | output | 16 | Resulting instruction pointer |
| nxt_sp | output | 16 | Resulting stack pointer |

## Verification
Two requests can collide in the same cycle. Entry and return can be raised together in one idle cycle, and a fresh start pulse can coincide with a memory access that is still stalled in a running sequence. The bench raises both starts at once and checks that the resulting frame, vector and stack pointer match an entry alone. It also injects both kinds of start in the middle of a sequence, while the memory model is inserting random wait cycles. It then checks that the outputs match the first request only and that exactly one `done` pulse was seen.

// File: rtl/irq_frame_pkg.sv
package irq_frame_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH_FL,
        S_PUSH_CS,
        S_PUSH_IP,
        S_RD_IP,
        S_RD_CS,
        S_POP_IP,
        S_POP_CS,
        S_POP_FL,
        S_FIN
    } seq_state_e;
endpackage

// File: rtl/irq_frame_ctrl.sv
module irq_frame_ctrl
    import irq_frame_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       entry_go,
    input  logic       ret_go,
    input  logic       mem_ready,
    output seq_state_e state,
    output logic       start_entry,
    output logic       start_ret,
    output logic       mode_ret,
    output logic       mem_req,
    output logic       mem_we,
    output logic       busy,
    output logic       done
);
    seq_state_e state_q, state_d;
    logic       mode_ret_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            mode_ret_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_entry)    mode_ret_q <= 1'b0;
            else if (start_ret) mode_ret_q <= 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d     = state_q;
        start_entry = 1'b0;
        start_ret   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (entry_go) begin
                    start_entry = 1'b1;
                    state_d     = S_PUSH_FL;
                end else if (ret_go) begin
                    start_ret = 1'b1;
                    state_d   = S_POP_IP;
                end
            end
            S_PUSH_FL: if (mem_ready) state_d = S_PUSH_CS;
            S_PUSH_CS: if (mem_ready) state_d = S_PUSH_IP;
            S_PUSH_IP: if (mem_ready) state_d = S_RD_IP;
            S_RD_IP:   if (mem_ready) state_d = S_RD_CS;
            S_RD_CS:   if (mem_ready) state_d = S_FIN;
            S_POP_IP:  if (mem_ready) state_d = S_POP_CS;
            S_POP_CS:  if (mem_ready) state_d = S_POP_FL;
            S_POP_FL:  if (mem_ready) state_d = S_FIN;
            S_FIN:     state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req = 1'b0;
        mem_we  = 1'b0;
        done    = 1'b0;
        busy    = (state_q != S_IDLE);
        unique case (state_q)
            S_PUSH_FL, S_PUSH_CS, S_PUSH_IP: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            S_RD_IP, S_RD_CS, S_POP_IP, S_POP_CS, S_POP_FL: mem_req = 1'b1;
            S_FIN:   done = 1'b1;
            default: ;
        endcase
    end

    assign state    = state_q;
    assign mode_ret = mode_ret_q;

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !entry_go && !ret_go) |=> !busy);
    // R10
    no_write_on_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_ret) |-> !mem_we);
endmodule

// File: rtl/irq_frame_dpath.sv
module irq_frame_dpath
    import irq_frame_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TYPE_W = 8,
    parameter int ADDR_W = 20,
    parameter int IE_BIT = 9,
    parameter int TF_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state,
    input  logic              start_entry,
    input  logic              start_ret,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [TYPE_W-1:0] irq_type,
    input  logic [DATA_W-1:0] cur_flags,
    input  logic [DATA_W-1:0] cur_cs,
    input  logic [DATA_W-1:0] cur_ip,
    input  logic [DATA_W-1:0] cur_ss,
    input  logic [DATA_W-1:0] cur_sp,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] nxt_flags,
    output logic [DATA_W-1:0] nxt_cs,
    output logic [DATA_W-1:0] nxt_ip,
    output logic [DATA_W-1:0] nxt_sp
);
    localparam int SEG_SHIFT  = ADDR_W - DATA_W;
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int ENTRY_SH   = 2;
    localparam logic [DATA_W-1:0] STEP = DATA_W'(WORD_BYTES);
    localparam logic [DATA_W-1:0] CLR_MASK =
        ~((DATA_W'(1) << IE_BIT) | (DATA_W'(1) << TF_BIT));

    logic [DATA_W-1:0] sp_q, fl_q, cs_q, ip_q, ss_q;
    logic [TYPE_W-1:0] typ_q;
    logic [ADDR_W-1:0] stk_addr, vec_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q  <= '0;
            fl_q  <= '0;
            cs_q  <= '0;
            ip_q  <= '0;
            ss_q  <= '0;
            typ_q <= '0;
        end else if (start_entry || start_ret) begin
            sp_q  <= start_entry ? (cur_sp - STEP) : cur_sp;
            fl_q  <= cur_flags;
            cs_q  <= cur_cs;
            ip_q  <= cur_ip;
            ss_q  <= cur_ss;
            typ_q <= irq_type;
        end else if (mem_ready) begin
            unique case (state)
                S_PUSH_FL: begin
                    sp_q <= sp_q - STEP;
                    fl_q <= fl_q & CLR_MASK;
                end
                S_PUSH_CS: sp_q <= sp_q - STEP;
                S_RD_IP:   ip_q <= mem_rdata;
                S_RD_CS:   cs_q <= mem_rdata;
                S_POP_IP: begin
                    ip_q <= mem_rdata;
                    sp_q <= sp_q + STEP;
                end
                S_POP_CS: begin
                    cs_q <= mem_rdata;
                    sp_q <= sp_q + STEP;
                end
                S_POP_FL: begin
                    fl_q <= mem_rdata;
                    sp_q <= sp_q + STEP;
                end
                default: ;
            endcase
        end
    end

    assign stk_addr = ADDR_W'({ss_q, SEG_SHIFT'(0)}) + ADDR_W'(sp_q);
    assign vec_addr = ADDR_W'({typ_q, ENTRY_SH'(0)});

    always_comb begin
        mem_addr  = stk_addr;
        mem_wdata = '0;
        unique case (state)
            S_PUSH_FL: mem_wdata = fl_q;
            S_PUSH_CS: mem_wdata = cs_q;
            S_PUSH_IP: mem_wdata = ip_q;
            S_RD_IP:   mem_addr  = vec_addr;
            S_RD_CS:   mem_addr  = vec_addr + ADDR_W'(WORD_BYTES);
            default: ;
        endcase
    end

    assign nxt_flags = fl_q;
    assign nxt_cs    = cs_q;
    assign nxt_ip    = ip_q;
    assign nxt_sp    = sp_q;

    // R3
    flags_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUSH_FL && mem_ready) |=> (!fl_q[IE_BIT] && !fl_q[TF_BIT]));
    // R2
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUSH_CS && mem_ready) |=> (sp_q == $past(sp_q) - STEP));
endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
    import irq_frame_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TYPE_W = 8,
    parameter int ADDR_W = 20,
    parameter int IE_BIT = 9,
    parameter int TF_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              entry_go,
    input  logic              ret_go,
    input  logic [TYPE_W-1:0] irq_type,
    input  logic [DATA_W-1:0] cur_flags,
    input  logic [DATA_W-1:0] cur_cs,
    input  logic [DATA_W-1:0] cur_ip,
    input  logic [DATA_W-1:0] cur_ss,
    input  logic [DATA_W-1:0] cur_sp,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] nxt_flags,
    output logic [DATA_W-1:0] nxt_cs,
    output logic [DATA_W-1:0] nxt_ip,
    output logic [DATA_W-1:0] nxt_sp
);
    seq_state_e state;
    logic       start_entry, start_ret, mode_ret;

    irq_frame_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .entry_go    (entry_go),
        .ret_go      (ret_go),
        .mem_ready   (mem_ready),
        .state       (state),
        .start_entry (start_entry),
        .start_ret   (start_ret),
        .mode_ret    (mode_ret),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .busy        (busy),
        .done        (done)
    );

    irq_frame_dpath #(
        .DATA_W (DATA_W),
        .TYPE_W (TYPE_W),
        .ADDR_W (ADDR_W),
        .IE_BIT (IE_BIT),
        .TF_BIT (TF_BIT)
    ) u_dpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .start_entry (start_entry),
        .start_ret   (start_ret),
        .mem_ready   (mem_ready),
        .mem_rdata   (mem_rdata),
        .irq_type    (irq_type),
        .cur_flags   (cur_flags),
        .cur_cs      (cur_cs),
        .cur_ip      (cur_ip),
        .cur_ss      (cur_ss),
        .cur_sp      (cur_sp),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .nxt_flags   (nxt_flags),
        .nxt_cs      (nxt_cs),
        .nxt_ip      (nxt_ip),
        .nxt_sp      (nxt_sp)
    );

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    // R3
    entry_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_ret) |-> (!nxt_flags[IE_BIT] && !nxt_flags[TF_BIT]));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !mem_we && !done));
endmodule

// File: tb/irq_frame_seq_tb.sv
`timescale 1ns/1ps
module irq_frame_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        entry_go = 1'b0, ret_go = 1'b0;
    logic [7:0]  irq_type = '0;
    logic [15:0] cur_flags = '0, cur_cs = '0, cur_ip = '0, cur_ss = '0, cur_sp = '0;
    logic        mem_req, mem_we, busy, done;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, nxt_flags, nxt_cs, nxt_ip, nxt_sp;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    int n_chk = 0, n_bad = 0;
    int done_cnt = 0, wr_cnt = 0, hold_err = 0;
    int wait_left = 0;
    logic [15:0] mem_w [int];

    always #4 clk = ~clk;

    irq_frame_seq dut_i (
        .clk(clk), .rst_n(rst_n), .entry_go(entry_go), .ret_go(ret_go),
        .irq_type(irq_type), .cur_flags(cur_flags), .cur_cs(cur_cs),
        .cur_ip(cur_ip), .cur_ss(cur_ss), .cur_sp(cur_sp),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .busy(busy), .done(done), .nxt_flags(nxt_flags), .nxt_cs(nxt_cs),
        .nxt_ip(nxt_ip), .nxt_sp(nxt_sp)
    );

    function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
        return 20'({seg, 4'h0}) + 20'(off);
    endfunction

    function automatic logic [15:0] rd_mem(input logic [19:0] a);
        if (mem_w.exists(int'(a))) return mem_w[int'(a)];
        return 16'hDEAD;
    endfunction

    // Memory model with random wait states; R7 hold monitor
    logic        p_req = 1'b0, p_rdy = 1'b0, p_we = 1'b0;
    logic [19:0] p_addr = '0;
    logic [15:0] p_wd = '0;
    always @(negedge clk) begin
        if (p_req && !p_rdy &&
            (!mem_req || mem_addr != p_addr || mem_we != p_we || mem_wdata != p_wd))
            hold_err++;
        mem_ready = 1'b0;
        if (mem_req) begin
            if (wait_left == 0 && p_req && !p_rdy) begin
                mem_ready = 1'b1;
            end else if (!p_req || p_rdy) begin
                wait_left = int'($urandom % 3);
                if (wait_left == 0) mem_ready = 1'b1;
            end else begin
                wait_left--;
                if (wait_left == 0) mem_ready = 1'b1;
            end
            if (mem_ready) begin
                if (mem_we) begin
                    mem_w[int'(mem_addr)] = mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata = rd_mem(mem_addr);
                end
            end
        end
        p_req = mem_req; p_rdy = mem_ready; p_we = mem_we;
        p_addr = mem_addr; p_wd = mem_wdata;
    end

    always @(posedge clk) if (rst_n && done) done_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int lim = 0;
        while (done !== 1'b1 && lim < 200) begin
            @(negedge clk);
            lim++;
        end
        if (lim >= 200) begin
            n_chk++; n_bad++;
            $display("FAIL R8 watchdog actual=timeout expected=done");
        end
    endtask

    task automatic pulse(input logic e, input logic r);
        @(negedge clk);
        entry_go = e; ret_go = r;
        @(negedge clk);
        entry_go = 1'b0; ret_go = 1'b0;
    endtask

    task automatic do_entry(input logic [7:0] t, input logic [15:0] fl, input logic [15:0] cs,
                            input logic [15:0] ip, input logic [15:0] ss, input logic [15:0] sp,
                            input logic both);
        logic [15:0] vip, vcs;
        int d0;
        vip = 16'($urandom); vcs = 16'($urandom);
        mem_w[int'({t, 2'b00})] = vip;
        mem_w[int'({t, 2'b00}) + 2] = vcs;
        irq_type = t; cur_flags = fl; cur_cs = cs; cur_ip = ip; cur_ss = ss; cur_sp = sp;
        d0 = done_cnt;
        pulse(1'b1, both);
        chk("R8 busy", 32'(busy), 32'd1);
        wait_done();
        chk("R3 flags", 32'(nxt_flags), 32'(fl & 16'hFCFF));
        chk("R4 ip", 32'(nxt_ip), 32'(vip));
        chk("R4 cs", 32'(nxt_cs), 32'(vcs));
        chk("R4 R6 sp", 32'(nxt_sp), 32'(16'(sp - 16'd6)));
        chk("R2 R6 flags slot", 32'(rd_mem(phys(ss, 16'(sp - 16'd2)))), 32'(fl));
        chk("R2 cs slot", 32'(rd_mem(phys(ss, 16'(sp - 16'd4)))), 32'(cs));
        chk("R2 ip slot", 32'(rd_mem(phys(ss, 16'(sp - 16'd6)))), 32'(ip));
        @(negedge clk);
        chk("R8 pulse", 32'(done), 32'd0);
        chk("R8 count", 32'(done_cnt - d0), 32'd1);
    endtask

    task automatic do_return(input logic [15:0] ss, input logic [15:0] sp);
        logic [15:0] rip, rcs, rfl;
        int w0;
        rip = 16'($urandom); rcs = 16'($urandom); rfl = 16'($urandom);
        mem_w[int'(phys(ss, sp))] = rip;
        mem_w[int'(phys(ss, 16'(sp + 16'd2)))] = rcs;
        mem_w[int'(phys(ss, 16'(sp + 16'd4)))] = rfl;
        cur_ss = ss; cur_sp = sp; cur_flags = 16'h0000;
        w0 = wr_cnt;
        pulse(1'b0, 1'b1);
        wait_done();
        chk("R5 ip", 32'(nxt_ip), 32'(rip));
        chk("R5 cs", 32'(nxt_cs), 32'(rcs));
        chk("R5 flags", 32'(nxt_flags), 32'(rfl));
        chk("R5 R6 sp", 32'(nxt_sp), 32'(16'(sp + 16'd6)));
        chk("R10 no writes", 32'(wr_cnt - w0), 32'd0);
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] fl, cs, ip, ss, sp;
        int d0;
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 req", 32'(mem_req), 32'd0);
        chk("R1 we", 32'(mem_we), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 32'({busy, mem_req, done}), 32'd0);

        // Directed corners
        do_entry(8'h00, 16'hFFFF, 16'h1234, 16'h5678, 16'h2000, 16'h0100, 1'b0);
        do_entry(8'hFF, 16'h0300, 16'hAAAA, 16'h5555, 16'h3000, 16'h0002, 1'b0); // R6 SP wrap
        do_entry(8'h10, 16'h0F0F, 16'h0001, 16'h0002, 16'hFFFF, 16'h0014, 1'b0); // R6 addr wrap
        do_return(16'h4000, 16'hFFFC);                                          // R6 SP wrap up
        do_entry(8'h21, 16'h0200, 16'h0BAD, 16'hF00D, 16'h5000, 16'h8000, 1'b1); // R9 both

        // R9 starts while busy are ignored
        irq_type = 8'h40; cur_flags = 16'h0F00; cur_cs = 16'h1111; cur_ip = 16'h2222;
        cur_ss = 16'h6000; cur_sp = 16'h0200;
        mem_w[32'h100] = 16'h3333; mem_w[32'h102] = 16'h4444;
        d0 = done_cnt;
        pulse(1'b1, 1'b0);
        @(negedge clk);
        irq_type = 8'h41; cur_sp = 16'h7777;
        pulse(1'b0, 1'b1);
        pulse(1'b1, 1'b0);
        wait_done();
        chk("R9 ip", 32'(nxt_ip), 32'h3333);
        chk("R9 cs", 32'(nxt_cs), 32'h4444);
        chk("R9 sp", 32'(nxt_sp), 32'h01FA);
        repeat (3) @(negedge clk);
        chk("R9 single done", 32'(done_cnt - d0), 32'd1);
        chk("R9 idle", 32'(busy), 32'd0);

        // Random entries with round-trip returns
        for (int i = 0; i < 30; i++) begin
            fl = 16'($urandom); cs = 16'($urandom); ip = 16'($urandom);
            ss = 16'($urandom % 16'hF000) + 16'h0100; sp = 16'($urandom);
            do_entry(8'($urandom), fl, cs, ip, ss, sp, 1'($urandom));
            cur_ss = ss; cur_sp = nxt_sp; cur_flags = '0;
            pulse(1'b0, 1'b1);
            wait_done();
            chk("R5 round ip", 32'(nxt_ip), 32'(ip));
            chk("R5 round cs", 32'(nxt_cs), 32'(cs));
            chk("R5 round flags", 32'(nxt_flags), 32'(fl));
            chk("R5 round sp", 32'(nxt_sp), 32'(sp));
            @(negedge clk);
            do_return(ss, 16'($urandom));
        end

        chk("R7 hold during stall", 32'(hold_err), 32'd0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule